// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. It holds a single register that acts as the compare value in output-compare mode and as the capture value in input-capture mode. The timer core supplies the running counter, the reload limit, the count direction and single-cycle overflow and underflow strobes. The channel does not own the counter. It raises a channel flag on a compare hit or on a capture, and an overcapture flag when a capture arrives before software has serviced the previous one.

In input-capture mode an asynchronous input pin passes through a two-flop synchroniser. A selected edge of the synchronised signal then copies the counter into the register. Software reads the register through `rd_data`. A read strobe tells the channel that the captured value has been consumed. Software writes zero to a flag with single-cycle clear strobes.

Top module: `cc_channel`

## Requirements
- R1: After reset, `flag`, `ovc_flag` and `rd_data` are all 0.
- R2: In output-compare mode (`mode_capture`=0), with register value ≤ `reload_val`, `flag` is 1 after the clock edge at which `cnt_val` equals the register value.
- R3: In output-compare mode with register value > `reload_val`, counter equality does not set `flag`. Instead `flag` sets on `ovf_pulse` when `count_down`=0 and on `unf_pulse` when `count_down`=1. The strobe for the other direction is ignored.
- R4: In input-capture mode, a level change on `cap_in` that is first sampled at clock edge k produces a capture at edge k+2. At that edge `rd_data` takes the `cnt_val` present at edge k+2 and `flag` becomes 1.
- R5: `edge_sel` selects the capture edge: 2'b00 and 2'b10 select rising, 2'b01 selects falling, 2'b11 selects both. An unselected edge changes neither `rd_data` nor `flag`.
- R6: In input-capture mode, `reg_rd_en` clears `flag` at the next edge. In output-compare mode, `reg_rd_en` has no effect on `flag`.
- R7: `flag_clr` clears `flag` in both modes. A set event at the same edge wins, and `flag` stays 1.
- R8: `ovc_flag` sets at a capture edge if `flag` is already 1. It never sets in output-compare mode.
- R9: `ovc_clr` clears `ovc_flag`, unless an overcapture happens at the same edge.
- R10: A capture and a `reg_rd_en` at the same edge leave `flag` at 1, and `rd_data` holds the newly captured value.
- R11: `reg_wr_en` loads `reg_wr_data` into the register. A capture at the same edge has priority.
- R12: In input-capture mode the compare logic never sets `flag`. In output-compare mode input edges neither capture nor set `flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_capture | input | 1 | 1 = input capture, 0 = output compare |
| edge_sel | input | 2 | Capture edge select |
| cap_in | input | 1 | Asynchronous capture input |
| cnt_val | input | W | Timer counter value |
| reload_val | input | W | Timer reload limit |
| count_down | input | 1 | 1 = timer counts down |
| ovf_pulse | input | 1 | Counter overflow strobe |
| unf_pulse | input | 1 | Counter underflow strobe |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | W | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| flag_clr | input | 1 | Clear channel flag |
| ovc_clr | input | 1 | Clear overcapture flag |
| flag | output | 1 | Channel flag |
| ovc_flag | output | 1 | Overcapture flag |
| rd_data | output | W | Compare/capture register value |

## Verification
The assertions check on every cycle how the flags and the register move relative to the internal compare-hit and capture events. These checks cover set-over-clear priority, a read clearing the flag, a capture loading the counter, and overcapture only arising from a capture onto a set flag. The assertions cannot show whether the events themselves fire at the right moments. Only the bench's scenarios show that: the two-cycle synchroniser latency, each edge-select encoding, and the fallback to overflow or underflow when the compare value lies above the reload limit.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE   = 2'b00,
    EDGE_FALL   = 2'b01,
    EDGE_RISE_B = 2'b10,
    EDGE_BOTH   = 2'b11
  } edge_sel_e;

  // Edge hit for a selected sensitivity, given previous and current level.
  function automatic logic cc_edge_hit(input logic [1:0] sel,
                                       input logic prev, input logic cur);
    logic rise, fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    case (sel)
      EDGE_FALL: cc_edge_hit = fall;
      EDGE_BOTH: cc_edge_hit = rise | fall;
      default:   cc_edge_hit = rise;
    endcase
  endfunction

  // Returns 1 when the compare value lies beyond the reload limit.
  function automatic logic cc_out_of_range(input logic [63:0] cmp,
                                           input logic [63:0] rel);
    cc_out_of_range = cmp > rel;
  endfunction

endpackage

// File: rtl/cc_edge_sync.sv
module cc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       async_in,
  input  logic [1:0] edge_sel,
  output logic       edge_hit
);
  import cc_pkg::*;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign edge_hit = cc_edge_hit(edge_sel, prev_q, chain_q[STAGES-1]);

endmodule

// File: rtl/cc_compare.sv
module cc_compare #(
  parameter int W = 16
) (
  input  logic         enable,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] reload_val,
  input  logic         count_down,
  input  logic         ovf_pulse,
  input  logic         unf_pulse,
  output logic         hit
);
  import cc_pkg::*;

  logic beyond;
  logic wrap_hit;
  logic eq_hit;

  always_comb begin
    beyond   = cc_out_of_range(64'(cmp_val), 64'(reload_val));
    wrap_hit = count_down ? unf_pulse : ovf_pulse;
    eq_hit   = (cnt_val == cmp_val);
    hit      = enable & (beyond ? wrap_hit : eq_hit);
  end

endmodule

// File: rtl/cc_flags.sv
module cc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic cap_evt,
  input  logic clr_evt,
  input  logic ovc_clr,
  output logic flag,
  output logic ovc_flag
);
  logic flag_q, ovc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ovc_q  <= 1'b0;
    end else begin
      if (set_evt)      flag_q <= 1'b1;
      else if (clr_evt) flag_q <= 1'b0;
      if (cap_evt && flag_q) ovc_q <= 1'b1;
      else if (ovc_clr)      ovc_q <= 1'b0;
    end
  end

  assign flag     = flag_q;
  assign ovc_flag = ovc_q;

endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_capture,
  input  logic [1:0]   edge_sel,
  input  logic         cap_in,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] reload_val,
  input  logic         count_down,
  input  logic         ovf_pulse,
  input  logic         unf_pulse,
  input  logic         reg_wr_en,
  input  logic [W-1:0] reg_wr_data,
  input  logic         reg_rd_en,
  input  logic         flag_clr,
  input  logic         ovc_clr,
  output logic         flag,
  output logic         ovc_flag,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] ccr_q;
  logic         edge_hit;
  logic         cap_evt;
  logic         cmp_evt;
  logic         rd_clr;
  logic         clr_evt;

  cc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cap_in),
    .edge_sel (edge_sel),
    .edge_hit (edge_hit)
  );

  cc_compare #(.W(W)) u_cmp (
    .enable     (~mode_capture),
    .cnt_val    (cnt_val),
    .cmp_val    (ccr_q),
    .reload_val (reload_val),
    .count_down (count_down),
    .ovf_pulse  (ovf_pulse),
    .unf_pulse  (unf_pulse),
    .hit        (cmp_evt)
  );

  assign cap_evt = mode_capture & edge_hit;
  assign rd_clr  = mode_capture & reg_rd_en;
  assign clr_evt = flag_clr | rd_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ccr_q <= '0;
    else if (cap_evt)   ccr_q <= cnt_val;
    else if (reg_wr_en) ccr_q <= reg_wr_data;
  end

  cc_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (cap_evt | cmp_evt),
    .cap_evt  (cap_evt),
    .clr_evt  (clr_evt),
    .ovc_clr  (ovc_clr),
    .flag     (flag),
    .ovc_flag (ovc_flag)
  );

  assign rd_data = ccr_q;

endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_capture,
  input logic         cap_evt,
  input logic         cmp_evt,
  input logic         reg_rd_en,
  input logic         reg_wr_en,
  input logic [W-1:0] reg_wr_data,
  input logic         ovc_clr,
  input logic [W-1:0] cnt_val,
  input logic         flag,
  input logic         ovc_flag,
  input logic [W-1:0] rd_data
);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt || cmp_evt) |=> flag);

  assert_no_spurious_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !cap_evt && !cmp_evt) |=> !flag);

  assert_capture_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (rd_data == $past(cnt_val)));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && mode_capture && reg_rd_en && !cap_evt && !cmp_evt) |=> !flag);

  assert_cap_read_same_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && reg_rd_en) |=> flag);

  assert_ovc_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovc_flag && !(cap_evt && flag)) |=> !ovc_flag);

  assert_ovc_compare_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_capture && !ovc_flag) |=> !ovc_flag);

  assert_ovc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovc_clr && !(cap_evt && flag)) |=> !ovc_flag);

  assert_write_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !cap_evt) |=> (rd_data == $past(reg_wr_data)));

  assert_reg_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && !cap_evt) |=> $stable(rd_data));

endmodule

bind cc_channel cc_channel_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_capture (mode_capture),
  .cap_evt      (cap_evt),
  .cmp_evt      (cmp_evt),
  .reg_rd_en    (reg_rd_en),
  .reg_wr_en    (reg_wr_en),
  .reg_wr_data  (reg_wr_data),
  .ovc_clr      (ovc_clr),
  .cnt_val      (cnt_val),
  .flag         (flag),
  .ovc_flag     (ovc_flag),
  .rd_data      (rd_data)
);

// File: tb/sim_cc_channel.sv
module sim_cc_channel;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_capture = 1'b0;
  logic [1:0]   edge_sel = 2'b00;
  logic         cap_in = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic [W-1:0] reload_val = '0;
  logic         count_down = 1'b0;
  logic         ovf_pulse = 1'b0;
  logic         unf_pulse = 1'b0;
  logic         reg_wr_en = 1'b0;
  logic [W-1:0] reg_wr_data = '0;
  logic         reg_rd_en = 1'b0;
  logic         flag_clr = 1'b0;
  logic         ovc_clr = 1'b0;
  logic         flag, ovc_flag;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_channel #(.W(W)) u0 (.*);

  typedef struct packed {
    logic [15:0] cmp;
    logic [15:0] rel;
    logic [15:0] cnt;
    logic        dn;
    logic        ov;
    logic        un;
    logic        ex;
  } vec_t;

  // Compare vectors: R2 equality hits, R3 out-of-range fallback to wrap strobes.
  localparam vec_t VEC [10] = '{
    '{16'd100, 16'd200, 16'd100, 1'b0, 1'b0, 1'b0, 1'b1},
    '{16'd100, 16'd200, 16'd99,  1'b0, 1'b0, 1'b0, 1'b0},
    '{16'd200, 16'd200, 16'd200, 1'b0, 1'b0, 1'b0, 1'b1},
    '{16'd300, 16'd200, 16'd300, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'd300, 16'd200, 16'd5,   1'b0, 1'b1, 1'b0, 1'b1},
    '{16'd300, 16'd200, 16'd5,   1'b0, 1'b0, 1'b1, 1'b0},
    '{16'd300, 16'd200, 16'd5,   1'b1, 1'b0, 1'b1, 1'b1},
    '{16'd300, 16'd200, 16'd5,   1'b1, 1'b1, 1'b0, 1'b0},
    '{16'd0,   16'd200, 16'd0,   1'b1, 1'b0, 1'b0, 1'b1},
    '{16'd100, 16'd200, 16'd100, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R1 flag", flag, 0);
    chk("R1 ovc", ovc_flag, 0);
    chk("R1 reg", rd_data, 0);
    rst_n = 1'b1;
    step(2);

    // Compare vectors
    foreach (VEC[i]) begin
      mode_capture = 1'b1; flag_clr = 1'b1; reg_wr_en = 1'b1;
      reg_wr_data = VEC[i].cmp; cnt_val = '0; ovf_pulse = 0; unf_pulse = 0;
      step(1);
      mode_capture = 1'b0; flag_clr = 1'b0; reg_wr_en = 1'b0;
      cnt_val = VEC[i].cnt; reload_val = VEC[i].rel; count_down = VEC[i].dn;
      ovf_pulse = VEC[i].ov; unf_pulse = VEC[i].un;
      step(1);
      chk($sformatf("R2/R3 vector %0d", i), flag, VEC[i].ex);
      ovf_pulse = 0; unf_pulse = 0;
    end

    // Capture mode setup
    mode_capture = 1'b1; edge_sel = 2'b00; cap_in = 1'b0; cnt_val = 16'h0;
    step(4);
    flag_clr = 1'b1; ovc_clr = 1'b1; step(1); flag_clr = 0; ovc_clr = 0;

    // R4 latency and sampled counter; R5 rising
    cap_in = 1'b1; cnt_val = 16'h1111; step(1);
    cnt_val = 16'h2222; step(1);
    chk("R4 no flag before k+2", flag, 0);
    cnt_val = 16'h1234; step(1);
    chk("R4 flag at k+2", flag, 1);
    chk("R4 captured value", rd_data, 16'h1234);

    // R5 falling ignored under rising select
    cap_in = 1'b0; cnt_val = 16'h7777; step(4);
    chk("R5 falling ignored reg", rd_data, 16'h1234);
    chk("R8 no overcapture without capture", ovc_flag, 0);

    // R8 overcapture
    cap_in = 1'b1; cnt_val = 16'h5678; step(3);
    chk("R8 ovc set", ovc_flag, 1);
    chk("R4 second capture", rd_data, 16'h5678);

    // R9 clear
    ovc_clr = 1'b1; step(1); ovc_clr = 1'b0;
    chk("R9 ovc cleared", ovc_flag, 0);

    // R6 read clears in capture mode
    reg_rd_en = 1'b1; step(1); reg_rd_en = 1'b0;
    chk("R6 read clears", flag, 0);

    // R5 falling select
    edge_sel = 2'b01; cnt_val = 16'h0F0F; cap_in = 1'b0; step(3);
    chk("R5 falling flag", flag, 1);
    chk("R5 falling value", rd_data, 16'h0F0F);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    cap_in = 1'b1; cnt_val = 16'h9999; step(4);
    chk("R5 rising ignored flag", flag, 0);
    chk("R5 rising ignored reg", rd_data, 16'h0F0F);

    // R5 both edges
    edge_sel = 2'b11; cnt_val = 16'h2222; cap_in = 1'b0; step(3);
    chk("R5 both fall value", rd_data, 16'h2222);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    cnt_val = 16'h3333; cap_in = 1'b1; step(3);
    chk("R5 both rise value", rd_data, 16'h3333);
    chk("R5 both rise flag", flag, 1);

    // R10 capture and read together (flag already set)
    cnt_val = 16'h4444; cap_in = 1'b0; step(2);
    reg_rd_en = 1'b1; step(1); reg_rd_en = 1'b0;
    chk("R10 flag stays", flag, 1);
    chk("R10 new value", rd_data, 16'h4444);
    chk("R8 ovc with read", ovc_flag, 1);
    ovc_clr = 1'b1; step(1); ovc_clr = 1'b0;

    // R7 set wins over clear
    cnt_val = 16'h4545; cap_in = 1'b1; step(2);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R7 set wins", flag, 1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R7 clear", flag, 0);
    ovc_clr = 1'b1; step(1); ovc_clr = 1'b0;

    // R11 capture beats write, then plain write
    cnt_val = 16'h5555; cap_in = 1'b0; step(2);
    reg_wr_en = 1'b1; reg_wr_data = 16'hBEEF; step(1); reg_wr_en = 1'b0;
    chk("R11 capture priority", rd_data, 16'h5555);
    reg_wr_en = 1'b1; step(1); reg_wr_en = 1'b0;
    chk("R11 write", rd_data, 16'hBEEF);

    // R12 compare disabled in capture mode
    flag_clr = 1'b1; ovc_clr = 1'b1; step(1); flag_clr = 0; ovc_clr = 0;
    cnt_val = 16'hBEEF; reload_val = 16'h0010; ovf_pulse = 1'b1; step(2);
    ovf_pulse = 1'b0;
    chk("R12 no compare in capture mode", flag, 0);

    // R12 capture disabled in compare mode; R6 read no effect
    mode_capture = 1'b0; reg_wr_en = 1'b1; reg_wr_data = 16'h0500;
    reload_val = 16'h1000; cnt_val = 16'h0; step(1); reg_wr_en = 1'b0;
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    cap_in = 1'b1; step(4); cap_in = 1'b0; step(4);
    chk("R12 no capture flag", flag, 0);
    chk("R12 no capture reg", rd_data, 16'h0500);
    cnt_val = 16'h0500; step(1); cnt_val = 16'h0;
    chk("R2 directed hit", flag, 1);
    reg_rd_en = 1'b1; step(1); reg_rd_en = 1'b0;
    chk("R6 read ignored in compare mode", flag, 1);
    chk("R8 no ovc in compare mode", ovc_flag, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule